// File: doc/BRIEF.md
# DRAM Power-Up Wake Sequencer

This block sits inside an asynchronous-DRAM controller and takes the memory from power-on to a state where normal accesses are allowed. After reset it keeps every strobe inactive for a programmed pause. It then issues a burst of wake-up cycles and raises a ready flag when the burst ends. The burst uses either plain row-strobe-only cycles or column-before-row refresh cycles, and a static configuration pin picks which.

While ready, the block watches for row-strobe activity. The access engine reports each of its row-strobe falling edges on an input strobe. If the gap since the last such edge, or since ready rose, grows past a programmed limit, the block drops ready and grant. If the engine is still busy, the block waits for it to go idle. It then repeats the wake-up burst with no pause and raises ready again.

Grant tells the access engine it may start cycles. Grant and ready move together. The block never issues a write cycle, so the memory's data output stays high-impedance.

Top module: `dram_wake_seq`

## Requirements
- R1: Reset (synchronous, active high) puts the block in its pause state. It holds ras_n_o, cas_n_o and we_n_o high and ready_o and grant_o low. Strobes then stay high for exactly PAUSE_CYC = CLK_MHZ*PAUSE_US cycles from the first cycle with reset low.
- R2: After the pause, exactly N_WAKE wake-up cycles are issued back to back, then ready_o rises.
- R3: With cbr_mode_i = 0, each wake-up cycle holds ras_n_o low for T_RAS cycles and then high for T_RP cycles. cas_n_o stays high. row_addr_o equals the cycle index, starting at 0, for the whole cycle.
- R4: With cbr_mode_i = 1, cas_n_o falls T_CSR cycles before ras_n_o falls. cas_n_o stays low while ras_n_o is low, and both rise together before T_RP high cycles. row_addr_o stays 0.
- R5: we_n_o stays high in every cycle, so no write cycle is ever issued.
- R6: ready_o and grant_o are low during any burst. Both rise in the cycle right after the last precharge cycle and are equal at all times. While ready, the strobes are high.
- R7: With no report on ras_fall_i, ready_o stays high for IDLE_CYC+1 cycles, where IDLE_CYC = CLK_MHZ*IDLE_US. Then a new burst starts at once with no pause.
- R8: A pulse on ras_fall_i while ready, sampled at the end of cycle s, restarts the idle window. ready_o then holds through cycle s+IDLE_CYC+1, and the burst begins in cycle s+IDLE_CYC+2.
- R9: If the idle limit expires while busy_i is high, ready_o and grant_o drop and all strobes stay high while busy_i stays high. The burst begins in the cycle after busy_i is first sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cbr_mode_i | input | 1 | Static: 1 selects column-before-row wake cycles, 0 selects row-only cycles |
| ras_fall_i | input | 1 | One-cycle report of a row-strobe falling edge issued by the access engine |
| busy_i | input | 1 | Access engine is mid-cycle |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |
| we_n_o | output | 1 | Active-low write enable (always high) |
| row_addr_o | output | ROW_W | Row address during row-only wake cycles |
| ready_o | output | 1 | Memory initialised and usable |
| grant_o | output | 1 | Access engine may start cycles |

## Verification
The bench builds the block with CLK_MHZ=1, PAUSE_US=6 and IDLE_US=30, which gives a six-cycle pause and a thirty-cycle idle limit. It uses T_RAS=3, T_RP=2, T_CSR=2 and the full eight wake cycles. These values bring the power-up pause, both burst shapes, the idle re-wake, the window restart and the busy hold-off within a few hundred cycles. That makes it possible to compare every strobe, address and flag value cycle by cycle against a waveform computed from the burst period, for both modes.

// File: rtl/dram_wake_pkg.sv
package dram_wake_pkg;
  typedef enum logic [2:0] {
    WS_PAUSE,
    WS_CSR,
    WS_RASLO,
    WS_RASHI,
    WS_READY,
    WS_DRAIN
  } wake_st_e;
endpackage

// File: rtl/dws_idle_watch.sv
module dws_idle_watch #(
  parameter int IDLE_CYC = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i || kick_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = arm_i && !kick_i && (cnt_q == LIMIT);
endmodule

// File: rtl/dws_wake_fsm.sv
module dws_wake_fsm
  import dram_wake_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 4,
  parameter int T_CSR     = 1,
  parameter int N_WAKE    = 8,
  parameter int ROW_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cbr_i,
  input  logic             busy_i,
  input  logic             expire_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ready_o
);
  localparam int M1      = (PAUSE_CYC > T_RAS) ? PAUSE_CYC : T_RAS;
  localparam int M2      = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int TMR_MAX = (M1 > M2) ? M1 : M2;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int IDX_W   = (N_WAKE > 1) ? $clog2(N_WAKE) : 1;
  localparam logic [TMR_W-1:0] LD_PAUSE = TMR_W'(PAUSE_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RAS   = TMR_W'(T_RAS - 1);
  localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] LD_CSR   = TMR_W'(T_CSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WAKE - 1);

  wake_st_e         st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cbr_q, cbr_d;
  logic             tmr_done;

  assign tmr_done = (tmr_q == '0);

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_done ? tmr_q : tmr_q - 1'b1;
    idx_d = idx_q;
    cbr_d = cbr_q;
    unique case (st_q)
      WS_PAUSE, WS_READY, WS_DRAIN: begin
        if ((st_q == WS_PAUSE && tmr_done) ||
            (st_q == WS_READY && expire_i && !busy_i) ||
            (st_q == WS_DRAIN && !busy_i)) begin
          idx_d = '0;
          cbr_d = cbr_i;
          st_d  = cbr_i ? WS_CSR : WS_RASLO;
          tmr_d = cbr_i ? LD_CSR : LD_RAS;
        end else if (st_q == WS_READY && expire_i) begin
          st_d = WS_DRAIN;
        end
      end
      WS_CSR: if (tmr_done) begin
        st_d  = WS_RASLO;
        tmr_d = LD_RAS;
      end
      WS_RASLO: if (tmr_done) begin
        st_d  = WS_RASHI;
        tmr_d = LD_RP;
      end
      WS_RASHI: if (tmr_done) begin
        if (idx_q == LAST_IDX) begin
          st_d = WS_READY;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = cbr_q ? WS_CSR : WS_RASLO;
          tmr_d = cbr_q ? LD_CSR : LD_RAS;
        end
      end
      default: st_d = WS_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WS_PAUSE;
      tmr_q <= LD_PAUSE;
      idx_q <= '0;
      cbr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      idx_q <= idx_d;
      cbr_q <= cbr_d;
    end
  end

  assign ras_n_o = (st_q != WS_RASLO);
  assign cas_n_o = !((st_q == WS_CSR) || (st_q == WS_RASLO && cbr_q));
  assign row_o   = ((st_q == WS_RASLO || st_q == WS_RASHI) && !cbr_q)
                   ? ROW_W'(idx_q) : '0;
  assign ready_o = (st_q == WS_READY);
endmodule

// File: rtl/dram_wake_seq.sv
module dram_wake_seq #(
  parameter int CLK_MHZ  = 100,
  parameter int PAUSE_US = 200,
  parameter int IDLE_US  = 8000,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int T_CSR    = 1,
  parameter int N_WAKE   = 8,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cbr_mode_i,
  input  logic             ras_fall_i,
  input  logic             busy_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             ready_o,
  output logic             grant_o
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int IDLE_CYC  = CLK_MHZ * IDLE_US;

  logic rdy;
  logic expire;

  dws_wake_fsm #(
    .PAUSE_CYC(PAUSE_CYC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR),
    .N_WAKE(N_WAKE), .ROW_W(ROW_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .cbr_i(cbr_mode_i), .busy_i(busy_i),
    .expire_i(expire), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .row_o(row_addr_o), .ready_o(rdy)
  );

  dws_idle_watch #(.IDLE_CYC(IDLE_CYC)) idle_i (
    .clk(clk), .rst(rst), .arm_i(rdy), .kick_i(ras_fall_i), .expire_o(expire)
  );

  assign we_n_o  = 1'b1;
  assign ready_o = rdy;
  assign grant_o = rdy;
endmodule

// File: rtl/dram_wake_seq_chk.sv
module dram_wake_seq_chk #(
  parameter int PAUSE_CYC = 20000
) (
  input logic clk,
  input logic rst,
  input logic cbr_mode_i,
  input logic busy_i,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic ready_o,
  input logic grant_o
);
  logic [31:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < 32'(PAUSE_CYC)) since_rst <= since_rst + 1;
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 32'(PAUSE_CYC)) |-> (ras_n_o && cas_n_o));

  assert_rasonly_cas_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !cbr_mode_i |-> cas_n_o);

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n_o) && cbr_mode_i) |-> $past(!cas_n_o));

  assert_ready_after_precharge_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> ($past(ras_n_o) && $past(cas_n_o)));

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (ready_o || grant_o) |-> (ras_n_o && cas_n_o));

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(ready_o) && busy_i) |-> (ras_n_o && cas_n_o && !grant_o));
endmodule

bind dram_wake_seq dram_wake_seq_chk #(.PAUSE_CYC(PAUSE_CYC)) chk_i (
  .clk(clk), .rst(rst), .cbr_mode_i(cbr_mode_i), .busy_i(busy_i),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .ready_o(ready_o), .grant_o(grant_o)
);

// File: tb/dram_wake_seq_tb_top.sv
module dram_wake_seq_tb_top;
  localparam int CLK_MHZ = 1, PAUSE_US = 6, IDLE_US = 30;
  localparam int T_RAS = 3, T_RP = 2, T_CSR = 2, N_WAKE = 8, ROW_W = 12;
  localparam int PAUSE = CLK_MHZ * PAUSE_US;
  localparam int IDLE  = CLK_MHZ * IDLE_US;

  logic clk = 1'b0, rst = 1'b1, cbr = 1'b0, ext = 1'b0, busy = 1'b0;
  logic ras_n, cas_n, we_n, ready, grant;
  logic [ROW_W-1:0] row;
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_wake_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .IDLE_US(IDLE_US), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_CSR(T_CSR), .N_WAKE(N_WAKE), .ROW_W(ROW_W)
  ) dut_i (
    .clk(clk), .rst(rst), .cbr_mode_i(cbr), .ras_fall_i(ext), .busy_i(busy),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .row_addr_o(row),
    .ready_o(ready), .grant_o(grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic er, input logic ec,
                           input int erow, input logic erdy);
    chk({tag, " ras_n"}, 32'(ras_n), 32'(er));
    chk({tag, " cas_n"}, 32'(cas_n), 32'(ec));
    chk({tag, " row"},   32'(row),   32'(erow));
    chk({tag, " ready"}, 32'(ready), 32'(erdy));
    chk("R6 grant==ready", 32'(grant), 32'(ready));
    chk("R5 we_n high",    32'(we_n),  32'd1);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic check_burst(input logic mode, input string ctx);
    int len;
    len = (mode ? T_CSR : 0) + T_RAS + T_RP;
    for (int j = 0; j < N_WAKE * len; j++) begin
      int i, ph;
      logic er, ec;
      i = j / len;
      ph = j % len;
      if (mode) begin
        ec = !(ph < T_CSR + T_RAS);
        er = !(ph >= T_CSR && ph < T_CSR + T_RAS);
        chk_state({ctx, " R4 R2"}, er, ec, 0, 1'b0);
      end else begin
        er = !(ph < T_RAS);
        chk_state({ctx, " R3 R2"}, er, 1'b1, i, 1'b0);
      end
      tick();
    end
  endtask

  task automatic ready_window(input int n, input string tag);
    for (int m = 0; m < n; m++) begin
      chk_state(tag, 1'b1, 1'b1, 0, 1'b1);
      tick();
    end
  endtask

  task automatic run_mode(input logic mode);
    cbr = mode;
    rst = 1'b1;
    ext = 1'b0;
    busy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    for (int k = 0; k < PAUSE; k++) begin
      chk_state("R1 pause", 1'b1, 1'b1, 0, 1'b0);
      tick();
    end
    check_burst(mode, "first");
    ready_window(IDLE + 1, "R7 idle window");
    check_burst(mode, "R7 rewake");
    ready_window(3, "R6 ready");
    chk_state("R8 kick cycle", 1'b1, 1'b1, 0, 1'b1);
    ext = 1'b1;
    tick();
    ext = 1'b0;
    ready_window(IDLE + 1, "R8 restarted window");
    check_burst(mode, "R8 rewake");
    busy = 1'b1;
    ready_window(IDLE + 1, "R9 window");
    for (int d = 0; d < 4; d++) begin
      chk_state("R9 drain", 1'b1, 1'b1, 0, 1'b0);
      if (d == 3) busy = 1'b0;
      tick();
    end
    check_burst(mode, "R9 after busy");
    ready_window(2, "R6 final ready");
  endtask

  initial begin
    @(negedge clk);
    chk_state("R1 reset", 1'b1, 1'b1, 0, 1'b0);
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired cyc=%0d actual=hung expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule